// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast digital clock, running at oscillator rate, by a total ratio of P×N + A. It does this by steering a dual-modulus prescaler, here built as a counter that divides by either P or P+1. Two counters set the division. The swallow value A fixes how many prescaler periods use the larger modulus P+1. The main value N fixes the total number of prescaler periods in one full division cycle. A select input picks the base modulus P from two modulus pairs that are fixed at build time.

The block gives one single-clock comparison pulse for each full division cycle. It also drives the modulus-control line. New select, swallow and main values are taken only at a cycle boundary, so a cycle that has already started always finishes with the settings it began with. Settings that are out of range do not stop the divider. It runs at a safe fallback ratio and raises a flag.

Top module: `psd_divider`

## Requirements
- R1: While reset is held, and after it is released until the first boundary, `pulse_o`, `mod_ctl_o` and `cfg_bad_o` are all 0.
- R2: With valid settings (A < N, N ≥ 3), the number of input clocks from one rising edge of `pulse_o` to the next is P×N + A. This holds for A at its smallest valid value, 0, where the ratio is P×N, and for A = N−1.
- R3: Within each division cycle, `mod_ctl_o` (1 = divide by P+1) is high for exactly A×(P+1) input clocks, and these clocks come first. `mod_ctl_o` changes only at the end of a prescaler period, and it is low when a cycle ends.
- R4: `pulse_o` is high for exactly one input clock per division cycle.
- R5: `sw_i` = 1 selects the modulus P = `P_SW1` (16 by default). `sw_i` = 0 selects P = `P_SW0` (32 by default).
- R6: `sw_i`, `swallow_i` and `main_i` are sampled only on the clock edge where `pulse_o` rises. A change made during a cycle has no effect on the length of that cycle or on its `mod_ctl_o` count.
- R7: If N < 3 or A ≥ N, that cycle runs with N = 3 and A = 0, so the ratio is 3×P and `mod_ctl_o` stays low.
- R8: `cfg_bad_o` changes only on the edge where `pulse_o` rises. It stays at 1 for the whole cycle that runs with invalid settings, and at 0 otherwise.
- R9: The full ranges are supported: A from 0 to 127 and N from 3 to 2047. With `sw_i` = 1, A = 127 and N = 2047 give 32879 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator-rate input clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_i | input | 1 | Modulus-pair select (1 = P_SW1, 0 = P_SW0) |
| swallow_i | input | 7 | Swallow value A |
| main_i | input | 11 | Main value N |
| mod_ctl_o | output | 1 | Prescaler modulus control (1 = P+1) |
| pulse_o | output | 1 | One-clock pulse at the end of each division cycle |
| cfg_bad_o | output | 1 | The current cycle runs on fallback settings |

## Verification
The bench builds the divider with its default modulus pair, 16 and 32. With these values, both select settings and both ends of the swallow and main ranges fit in a short run, including the longest ratio of 32879 clocks. Random main values are kept below 41, so many complete cycles, each with different settings, can be compared clock by clock. In every cycle the bench also counts the high clocks of the modulus-control line, which checks the swallow count directly and not only the total ratio.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int A_W     = 7;
  localparam int N_W     = 11;
  localparam int N_FLOOR = 3;

  typedef logic [A_W-1:0] swl_t;
  typedef logic [N_W-1:0] main_t;

  // settings are usable when N reaches the floor and A stays below N
  function automatic logic cfg_valid(swl_t a, main_t n);
    return (n >= main_t'(N_FLOOR)) && (main_t'(a) < n);
  endfunction

  function automatic main_t eff_main(swl_t a, main_t n);
    return cfg_valid(a, n) ? n : main_t'(N_FLOOR);
  endfunction

  function automatic swl_t eff_swl(swl_t a, main_t n);
    return cfg_valid(a, n) ? a : '0;
  endfunction
endpackage

// File: rtl/psd_cfg_stage.sv
// Samples the settings at a cycle boundary and holds the base modulus.
module psd_cfg_stage
  import psd_pkg::*;
#(
  parameter int P_SW1 = 16,
  parameter int P_SW0 = 32,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          sw_i,
  input  swl_t          a_i,
  input  main_t         n_i,
  output swl_t          nxt_a,
  output main_t         nxt_n,
  output logic [PW-1:0] base_q,
  output logic          bad_q
);
  localparam logic [PW-1:0] P1 = PW'(P_SW1);
  localparam logic [PW-1:0] P0 = PW'(P_SW0);

  assign nxt_a = eff_swl(a_i, n_i);
  assign nxt_n = eff_main(a_i, n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= P0;
      bad_q  <= 1'b0;
    end else if (load) begin
      base_q <= sw_i ? P1 : P0;
      bad_q  <= !cfg_valid(a_i, n_i);
    end
  end
endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus counter: a period lasts base or base+1 input clocks.
module psd_prescaler #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] base_p,
  input  logic          plus1,
  output logic          tick
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;

  assign last = plus1 ? base_p : base_p - PW'(1);
  assign tick = (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/psd_swallow_seq.sv
// Counts prescaler periods and selects the modulus for each one.
module psd_swallow_seq
  import psd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  swl_t  ld_a,
  input  main_t ld_n,
  output logic  mod_ctl,
  output logic  cyc_end
);
  swl_t  a_rem;
  main_t n_rem;

  assign mod_ctl = (a_rem != '0);
  assign cyc_end = tick && (n_rem == main_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rem <= '0;
      n_rem <= main_t'(1);
    end else if (cyc_end) begin
      a_rem <= ld_a;
      n_rem <= ld_n;
    end else if (tick) begin
      n_rem <= n_rem - main_t'(1);
      if (a_rem != '0) a_rem <= a_rem - swl_t'(1);
    end
  end
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int P_SW1 = 16,
  parameter int P_SW0 = 32
) (
  input  logic           clk_vco,
  input  logic           rst_n,
  input  logic           sw_i,
  input  logic [A_W-1:0] swallow_i,
  input  logic [N_W-1:0] main_i,
  output logic           mod_ctl_o,
  output logic           pulse_o,
  output logic           cfg_bad_o
);
  localparam int PMAX = (P_SW1 > P_SW0) ? P_SW1 : P_SW0;
  localparam int PW   = $clog2(PMAX + 2);

  logic [PW-1:0] base_p;
  logic          pre_tick;
  logic          cyc_end;
  swl_t          nxt_a;
  main_t         nxt_n;

  psd_cfg_stage #(.P_SW1(P_SW1), .P_SW0(P_SW0), .PW(PW)) u_cfg (
    .clk(clk_vco), .rst_n(rst_n), .load(cyc_end), .sw_i(sw_i),
    .a_i(swallow_i), .n_i(main_i), .nxt_a(nxt_a), .nxt_n(nxt_n),
    .base_q(base_p), .bad_q(cfg_bad_o)
  );

  psd_prescaler #(.PW(PW)) u_pre (
    .clk(clk_vco), .rst_n(rst_n), .base_p(base_p),
    .plus1(mod_ctl_o), .tick(pre_tick)
  );

  psd_swallow_seq u_seq (
    .clk(clk_vco), .rst_n(rst_n), .tick(pre_tick), .ld_a(nxt_a),
    .ld_n(nxt_n), .mod_ctl(mod_ctl_o), .cyc_end(cyc_end)
  );

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else pulse_o <= cyc_end;
  end
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
  parameter int P_SW1 = 16,
  parameter int P_SW0 = 32
) (
  input logic clk,
  input logic rst_n,
  input logic pre_tick,
  input logic cyc_end,
  input logic mod_ctl,
  input logic pulse,
  input logic bad
);
  localparam int PMAX    = (P_SW1 > P_SW0) ? P_SW1 : P_SW0;
  localparam int MAX_GAP = PMAX * ((1 << psd_pkg::N_W) - 1) + (1 << psd_pkg::A_W) + 2;

  int unsigned gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 0;
    else if (pulse) gap <= 0;
    else gap <= gap + 1;
  end

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  p_pulse_follows_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> pulse);
  p_mod_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_tick |=> $stable(mod_ctl));
  p_end_low_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> !mod_ctl);
  p_flag_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(bad));
  p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= MAX_GAP);
endmodule

bind psd_divider psd_divider_chk #(.P_SW1(P_SW1), .P_SW0(P_SW0)) u_chk (
  .clk(clk_vco), .rst_n(rst_n), .pre_tick(pre_tick), .cyc_end(cyc_end),
  .mod_ctl(mod_ctl_o), .pulse(pulse_o), .bad(cfg_bad_o)
);

// File: tb/sim_psd_divider.sv
`timescale 1ns/1ps
module sim_psd_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw = 1'b0;
  logic [6:0]  a_in = '0;
  logic [10:0] n_in = 11'd3;
  logic        mod_ctl, pulse, bad;
  int n_cmp = 0;
  int n_mis = 0;

  always #4 clk = ~clk;

  psd_divider u0 (
    .clk_vco(clk), .rst_n(rst_n), .sw_i(sw), .swallow_i(a_in),
    .main_i(n_in), .mod_ctl_o(mod_ctl), .pulse_o(pulse), .cfg_bad_o(bad)
  );

  localparam int NCASE = 34;
  logic        c_sw [NCASE+1];
  logic [6:0]  c_a  [NCASE+1];
  logic [10:0] c_n  [NCASE+1];

  function automatic bit ok_cfg(int a, int n);
    return (n >= 3) && (a < n);
  endfunction
  function automatic int base_of(bit s);
    return s ? 16 : 32;
  endfunction
  function automatic int exp_len(bit s, int a, int n);
    if (!ok_cfg(a, n)) return 3 * base_of(s);
    return base_of(s) * n + a;
  endfunction
  function automatic int exp_hi(bit s, int a, int n);
    if (!ok_cfg(a, n)) return 0;
    return a * (base_of(s) + 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!pulse);
  endtask

  // entered at a negedge where pulse is high; exits at the next such negedge
  task automatic measure(input int i);
    int len = 0;
    int hi = 0;
    int b = bad;
    check($sformatf("R8 flag case %0d", i), b, ok_cfg(c_a[i], c_n[i]) ? 0 : 1);
    sw = c_sw[i+1]; a_in = c_a[i+1]; n_in = c_n[i+1];  // R6: mid-cycle change
    do begin
      hi += mod_ctl;
      len++;
      if (len == 2) check($sformatf("R4 width case %0d", i), pulse, 0);
      @(negedge clk);
      if (!pulse && bad != b) check($sformatf("R8 stable case %0d", i), bad, b);
    end while (!pulse);
    check($sformatf("R2/R5/R6/R7 ratio case %0d sw=%0d a=%0d n=%0d", i, c_sw[i], c_a[i], c_n[i]),
          len, exp_len(c_sw[i], c_a[i], c_n[i]));
    check($sformatf("R3 swallow clocks case %0d", i), hi, exp_hi(c_sw[i], c_a[i], c_n[i]));
  endtask

  task automatic set_case(input int i, input bit s, input int a, input int n);
    c_sw[i] = s; c_a[i] = 7'(a); c_n[i] = 11'(n);
  endtask

  initial begin
    void'($urandom(32'd4711));
    set_case(0, 1, 5, 10);     // R2, R5 sw=1
    set_case(1, 0, 5, 10);     // R5 sw=0
    set_case(2, 1, 0, 3);      // R2 A=0 at floor
    set_case(3, 0, 2, 3);      // R2 A=N-1
    set_case(4, 1, 3, 3);      // R7 A>=N
    set_case(5, 0, 0, 2);      // R7 N<3
    set_case(6, 1, 9, 0);      // R7 N=0
    set_case(7, 1, 127, 2047); // R9 full range
    set_case(8, 0, 0, 3);
    for (int i = 9; i <= NCASE; i++) begin
      int n = 3 + int'($urandom % 38);
      int a = ($urandom % 6 == 0) ? int'($urandom % 128) : int'($urandom % n);
      set_case(i, 1'($urandom % 2), a, n);
    end

    repeat (5) @(negedge clk);
    check("R1 pulse in reset", pulse, 0);
    check("R1 modctl in reset", mod_ctl, 0);
    check("R1 flag in reset", bad, 0);
    rst_n = 1'b1;
    sw = c_sw[0]; a_in = c_a[0]; n_in = c_n[0];
    @(negedge clk);
    check("R1 pulse after release", pulse, 0);
    check("R1 modctl after release", mod_ctl, 0);
    check("R1 flag after release", bad, 0);
    wait_pulse();
    for (int i = 0; i < NCASE; i++) measure(i);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_mis++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule